// File: doc/BRIEF.md
# Infrared Pulse-Timing Capture Receiver

This block watches the output of an external infrared (or UHF) demodulator and turns each symbol of a remote-control burst into two numbers: how many sample ticks the input was active (the mark), and how many ticks passed from the symbol's rising edge to the next rising edge (the period). The pairs go into a small FIFO that software drains over a simple register bus. When no further rising edge arrives within a programmable limit, the last symbol is closed with the period code 0xFFFF and a last-symbol interrupt is raised. Software can then hand the burst to a protocol decoder.

The input passes through a two-flop synchronizer, an optional polarity inversion and a programmable glitch filter. All timing is counted in sample ticks produced by dividing the system clock. The parameter `BASE` places the receive register window. The default, 0x40, is the infrared set, and 0x80 gives the UHF set with the same layout. The divisor register stays at 0x64 in either case.

Top module: `ir_pulse_capture`

## Requirements
- R1: After reset, interrupt enable, receive enable, polarity and noise limit read 0, the maximum period (BASE+0x14) reads 0x5000, the divisor (0x64) reads 5, the receive status reads 0 and `irq` is low.
- R2: With capture enabled (BASE+0x10 bit 0), each rising edge after the first pushes one pair. The mark is the count of active ticks since the previous rising edge, and the period is the count of ticks between the two rising edges.
- R3: When no rising edge follows within the maximum period (BASE+0x14, in ticks), a pair with period 0xFFFF is pushed and interrupt status bit 1 is set. A period exactly equal to the maximum is measured normally.
- R4: Reading the period register (BASE+0x04) does not pop. Reading the mark register (BASE+0x00) returns the oldest mark and pops the pair. Pairs leave in arrival order. The receive status (BASE+0x2C) holds the FIFO fill count in bits 15:8. A mark read on an empty FIFO returns 0.
- R5: The FIFO holds 8 pairs. A push into a full FIFO is dropped and sets overrun (interrupt status bit 2, mirrored in receive status bit 2). Overrun stays set until cleared. Status bit 3 is set when the FIFO becomes full.
- R6: Interrupt status (BASE+0x0C; bit 0 pair stored, bit 1 last symbol, bit 2 overrun, bit 3 full) is cleared by writing ones to BASE+0x18. `irq` is high exactly when a status bit is set whose enable bit (BASE+0x08) is set.
- R7: A pulse on the synchronized input that lasts N ticks or fewer, where N is the noise limit (BASE+0x1C), is ignored. Longer pulses are measured with their true length.
- R8: Writing 1 to BASE+0x28 makes a low pin level the active (mark) level.
- R9: While receive enable is 0, no pair is pushed and no status bit is set by the input.
- R10: The sample tick is the clock divided by the divisor (0x64), and marks and periods are counted in those ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_pin | input | 1 | Demodulated receiver pin, asynchronous |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops on the mark register) |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the address |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest states to reach are the ones where an edge falls exactly on a limit. A period equal to the maximum must be measured, while one tick more must close the symbol with 0xFFFF. A glitch exactly as long as the noise limit must vanish, while one tick longer must pass. The bench drives the pin on whole clock cycles with the divisor set to 1, so every pulse length is an exact tick count, and it places the edges at the limit and one tick past it. The overrun case is reached by sending a nine-symbol burst into the eight-entry FIFO without draining it, so the closing timeout pair is the one that is dropped.

// File: rtl/ir_pulse_capture.sv
module ir_pulse_capture #(
  parameter logic [7:0]  BASE       = 8'h40,
  parameter int          DEPTH      = 8,
  parameter logic [15:0] DIV_RST    = 16'd5,
  parameter logic [15:0] MAXSYM_RST = 16'h5000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_pin,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        irq
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);
  localparam logic [7:0] A_MARK = BASE,          A_SYM   = BASE + 8'h04;
  localparam logic [7:0] A_IEN  = BASE + 8'h08,  A_IST   = BASE + 8'h0C;
  localparam logic [7:0] A_EN   = BASE + 8'h10,  A_MAX   = BASE + 8'h14;
  localparam logic [7:0] A_ICLR = BASE + 8'h18,  A_NOISE = BASE + 8'h1C;
  localparam logic [7:0] A_POL  = BASE + 8'h28,  A_STAT  = BASE + 8'h2C;
  localparam logic [7:0] A_DIV  = 8'h64;

  function automatic logic [15:0] sat_inc(input logic [15:0] v);
    return (v == 16'hFFFF) ? v : v + 16'd1;
  endfunction

  logic [15:0] div_q, max_q, noise_q, div_cnt, nf_cnt, mark_q, sym_q;
  logic        pol_q, en_q, filt_q, filt_d, busy_q;
  logic [3:0]  ien_q, ist_q;
  logic [1:0]  sync_q;
  logic [31:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0] cnt_q;

  logic w_iclr;
  assign w_iclr = bus_wr && bus_addr == A_ICLR;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_q <= DIV_RST; max_q <= MAXSYM_RST; noise_q <= '0;
      pol_q <= 1'b0; en_q <= 1'b0; ien_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_DIV)   div_q   <= bus_wdata;
      if (bus_addr == A_MAX)   max_q   <= bus_wdata;
      if (bus_addr == A_NOISE) noise_q <= bus_wdata;
      if (bus_addr == A_POL)   pol_q   <= bus_wdata[0];
      if (bus_addr == A_EN)    en_q    <= bus_wdata[0];
      if (bus_addr == A_IEN)   ien_q   <= bus_wdata[3:0];
    end

  logic [16:0] div_nxt;
  logic        tick, raw_act, rise, timeout, push, acc, pop;
  assign div_nxt = {1'b0, div_cnt} + 17'd1;
  assign tick    = div_nxt >= {1'b0, div_q};
  assign raw_act = sync_q[1] ^ pol_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_cnt <= '0; sync_q <= '0; filt_q <= 1'b0; filt_d <= 1'b0; nf_cnt <= '0;
    end else begin
      div_cnt <= tick ? 16'd0 : div_nxt[15:0];
      sync_q  <= {sync_q[0], rx_pin};
      if (tick) begin
        filt_d <= filt_q;
        if (raw_act == filt_q) nf_cnt <= '0;
        else if (nf_cnt >= noise_q) begin
          filt_q <= raw_act;
          nf_cnt <= '0;
        end else nf_cnt <= nf_cnt + 16'd1;
      end
    end

  assign rise    = tick && filt_q && !filt_d;
  assign timeout = tick && busy_q && !rise && sym_q >= max_q;
  assign push    = en_q && busy_q && (rise || timeout);
  assign acc     = push && cnt_q != FULL;
  assign pop     = bus_rd && bus_addr == A_MARK && cnt_q != '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy_q <= 1'b0; mark_q <= '0; sym_q <= '0;
    end else if (!en_q) busy_q <= 1'b0;
    else if (tick) begin
      if (rise) begin
        busy_q <= 1'b1; mark_q <= 16'd1; sym_q <= 16'd1;
      end else if (timeout) busy_q <= 1'b0;
      else if (busy_q) begin
        sym_q <= sat_inc(sym_q);
        if (filt_q) mark_q <= sat_inc(mark_q);
      end
    end

  always_ff @(posedge clk)
    if (acc) mem_q[wp_q] <= {mark_q, timeout ? 16'hFFFF : sym_q};

  logic [3:0] ist_set;
  assign ist_set = {acc && cnt_q == FULL - 1'b1, push && !acc, push && timeout, acc};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0; ist_q <= '0;
    end else begin
      if (acc) wp_q <= wp_q + 1'b1;
      if (pop) rp_q <= rp_q + 1'b1;
      cnt_q <= cnt_q + {{AW{1'b0}}, acc} - {{AW{1'b0}}, pop};
      ist_q <= (ist_q & ~(w_iclr ? bus_wdata[3:0] : 4'h0)) | ist_set;
    end

  assign irq = |(ist_q & ien_q);

  logic [31:0] head;
  assign head = mem_q[rp_q];

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_MARK:  if (cnt_q != '0) bus_rdata = head[31:16];
      A_SYM:   if (cnt_q != '0) bus_rdata = head[15:0];
      A_IEN:   bus_rdata = {12'b0, ien_q};
      A_IST:   bus_rdata = {12'b0, ist_q};
      A_EN:    bus_rdata = {15'b0, en_q};
      A_MAX:   bus_rdata = max_q;
      A_NOISE: bus_rdata = noise_q;
      A_POL:   bus_rdata = {15'b0, pol_q};
      A_STAT:  bus_rdata = {8'(cnt_q), 5'b0, ist_q[2], 2'b0};
      A_DIV:   bus_rdata = div_q;
      default: bus_rdata = '0;
    endcase
  end

  // R5
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= FULL);
  // R5
  overrun_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ist_q[2] && !(w_iclr && bus_wdata[2]) |=> ist_q[2]);
  // R9
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n) !en_q |=> !busy_q);
  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1 || cnt_q + 1 == $past(cnt_q));
  // R3
  last_flag_chk: assert property (@(posedge clk) disable iff (!rst_n) push && timeout |=> ist_q[1]);
endmodule

// File: tb/ir_pulse_capture_tb.sv
module ir_pulse_capture_tb;
  logic clk = 1'b0, rst_n = 1'b0, rx_pin = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic irq;
  logic inv = 1'b0;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  localparam logic [7:0] A_MARK = 8'h40, A_SYM = 8'h44, A_IEN = 8'h48, A_IST = 8'h4C;
  localparam logic [7:0] A_EN = 8'h50, A_MAX = 8'h54, A_ICLR = 8'h58, A_NOISE = 8'h5C;
  localparam logic [7:0] A_POL = 8'h68, A_STAT = 8'h6C, A_DIV = 8'h64;

  always #10 clk = ~clk;

  ir_pulse_capture u_dut (.clk(clk), .rst_n(rst_n), .rx_pin(rx_pin), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic drive(input bit act, input int n);
    rx_pin = act ^ inv;
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int h, input int l);
    drive(1'b1, h); drive(1'b0, l);
  endtask

  task automatic pop_chk(input string req, input logic [15:0] m, input logic [15:0] s);
    rd_chk({req, " period"}, A_SYM, s);
    rd_chk({req, " mark"}, A_MARK, m);
  endtask

  task automatic t_reset;
    chk("R1 irq", irq, 0);
    rd_chk("R1 ien", A_IEN, 0);
    rd_chk("R1 en", A_EN, 0);
    rd_chk("R1 pol", A_POL, 0);
    rd_chk("R1 noise", A_NOISE, 0);
    rd_chk("R1 max", A_MAX, 16'h5000);
    rd_chk("R1 div", A_DIV, 5);
    rd_chk("R1 stat", A_STAT, 0);
  endtask

  task automatic t_train;
    pulse(5, 10); pulse(8, 4); pulse(3, 60);
    rd_chk("R4 fill count", A_STAT, 16'h0300);
    rd_chk("R6 status", A_IST, 4'h3);
    chk("R6 irq set", irq, 1);
    pop_chk("R2 first", 5, 15);
    pop_chk("R2 second", 8, 12);
    pop_chk("R3 last", 3, 16'hFFFF);
    rd_chk("R4 drained", A_STAT, 0);
    wr(A_ICLR, 16'hF);
    rd_chk("R6 cleared", A_IST, 0);
    chk("R6 irq clear", irq, 0);
  endtask

  task automatic t_boundary;
    pulse(4, 36); pulse(4, 60);
    pop_chk("R3 equal max", 4, 40);
    pop_chk("R3 equal max end", 4, 16'hFFFF);
    pulse(4, 37); pulse(4, 60);
    pop_chk("R3 over max", 4, 16'hFFFF);
    pop_chk("R3 over max end", 4, 16'hFFFF);
    rd_chk("R3 over max count", A_STAT, 0);
    wr(A_ICLR, 16'hF);
  endtask

  task automatic t_noise;
    wr(A_NOISE, 3);
    pulse(6, 4); pulse(3, 4); pulse(4, 60);
    pop_chk("R7 glitch ignored", 6, 17);
    pop_chk("R7 limit plus one", 4, 16'hFFFF);
    rd_chk("R7 count", A_STAT, 0);
    wr(A_NOISE, 0);
    wr(A_ICLR, 16'hF);
  endtask

  task automatic t_polarity;
    wr(A_EN, 0);
    wr(A_POL, 1);
    inv = 1'b1;
    drive(1'b0, 10);
    wr(A_EN, 1);
    pulse(7, 9); pulse(5, 60);
    pop_chk("R8 inverted", 7, 16);
    pop_chk("R8 inverted end", 5, 16'hFFFF);
    wr(A_EN, 0);
    wr(A_POL, 0);
    inv = 1'b0;
    drive(1'b0, 10);
    wr(A_EN, 1);
    wr(A_ICLR, 16'hF);
  endtask

  task automatic t_disable;
    wr(A_EN, 0);
    pulse(5, 10); pulse(5, 10); pulse(5, 60);
    rd_chk("R9 no pairs", A_STAT, 0);
    rd_chk("R9 no status", A_IST, 0);
    rd_chk("R4 empty mark read", A_MARK, 0);
    rd_chk("R4 empty stays empty", A_STAT, 0);
    wr(A_EN, 1);
  endtask

  task automatic t_irq_mask;
    wr(A_IEN, 0);
    pulse(3, 60);
    rd_chk("R6 masked status", A_IST, 4'h3);
    chk("R6 masked irq", irq, 0);
    wr(A_IEN, 4'h2);
    chk("R6 unmasked irq", irq, 1);
    pop_chk("R3 single", 3, 16'hFFFF);
    wr(A_ICLR, 16'h2);
    chk("R6 irq after clear", irq, 0);
    wr(A_ICLR, 16'hF);
    wr(A_IEN, 16'hF);
  endtask

  task automatic t_overrun;
    for (int i = 0; i < 8; i++) pulse(3, 5);
    pulse(3, 60);
    rd_chk("R5 status", A_IST, 4'hF);
    rd_chk("R5 fill and overrun", A_STAT, 16'h0804);
    drive(1'b0, 30);
    rd_chk("R5 overrun held", A_STAT, 16'h0804);
    wr(A_ICLR, 16'h4);
    rd_chk("R5 overrun cleared", A_IST, 4'hB);
    for (int i = 0; i < 8; i++) pop_chk("R5 kept pair", 3, 8);
    rd_chk("R5 drained", A_STAT, 0);
    wr(A_ICLR, 16'hF);
  endtask

  task automatic t_divider;
    wr(A_DIV, 5);
    pulse(20, 30); pulse(10, 300);
    pop_chk("R10 divided", 4, 10);
    pop_chk("R10 divided end", 2, 16'hFFFF);
    wr(A_ICLR, 16'hF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    wr(A_DIV, 1);
    wr(A_MAX, 40);
    wr(A_IEN, 16'hF);
    wr(A_EN, 1);
    drive(1'b0, 5);
    t_train;
    t_boundary;
    t_noise;
    t_polarity;
    t_disable;
    t_irq_mask;
    t_overrun;
    t_divider;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule